// File: doc/BRIEF.md
# Decode-Stage Branch Hazard and Forwarding Unit

This block sits beside the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback, one cycle each) whose conditional branches are resolved in decode by a dedicated comparator, not by the ALU. It looks at the branch opcode and source register numbers in decode. It also looks at the destination register, write enable and load flag of the instructions sitting in the execute and memory pipeline registers. From these it decides whether the branch must wait, whether each comparator operand should come from the register file or from the execute/memory ALU result, and whether the branch is taken.

Three branch kinds exist. An equality branch compares two registers. A zero test and a nonzero test each look at one register only, so no subtraction is needed. There is no delay slot, so a taken branch discards the instruction fetched behind it. While the stall output is high, the surrounding pipeline holds the program counter and the fetch/decode register and puts a bubble into the decode/execute register. The register file writes before it reads within a cycle, so a producer in writeback is never a concern and has no inputs here.

Top module: `decode_branch_hazard`

## Requirements
- R1: With opcode 2'b01 (equality branch) and no stall, `br_taken` is 1 exactly when the two resolved comparator operands are equal.
- R2: With opcode 2'b10 (zero test) and no stall, `br_taken` is 1 exactly when resolved operand A is zero. With opcode 2'b11 (nonzero test) it is 1 exactly when operand A is nonzero. For both, source B takes no part: it never causes a stall, `fwd_sel_b` stays 0 and its data is ignored.
- R3: With opcode 2'b00 (not a branch), `stall`, `fwd_sel_a`, `fwd_sel_b`, `br_taken` and `fetch_flush` are all 0, whatever the pipeline holds.
- R4: A write-enabled instruction in execute whose destination equals a source register the branch uses raises `stall`, whether or not it is a load.
- R5: A load in memory whose destination equals a used source register raises `stall`. A non-load in memory never raises `stall`.
- R6: A write-enabled non-load in memory whose destination equals a used source sets that operand's forward select to 1, and the comparator then uses `mem_alu_result` for that operand.
- R7: Register 0 never raises `stall` and never sets a forward select.
- R8: While `stall` is 1, `br_taken` and `fetch_flush` are 0. Otherwise `fetch_flush` equals `br_taken`.
- R9: When no instruction in memory matches a used source, that operand's forward select is 0 and the comparator uses the register-file read data. This covers a producer that has already moved on to writeback.
- R10: A branch directly behind an ALU producer of its source stalls exactly one cycle and then resolves with forward select 1. A branch directly behind a load producer stalls exactly two cycles and then resolves from register-file data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_br_op | input | 2 | Decode opcode: 00 none, 01 equality, 10 zero test, 11 nonzero test |
| id_src_a | input | AW | Source register A of the decode branch |
| id_src_b | input | AW | Source register B (used by the equality branch only) |
| rf_data_a | input | DW | Register-file read data for source A |
| rf_data_b | input | DW | Register-file read data for source B |
| ex_dst | input | AW | Destination register of the instruction in execute |
| ex_wr_en | input | 1 | Instruction in execute writes a register |
| mem_dst | input | AW | Destination register of the instruction in memory |
| mem_wr_en | input | 1 | Instruction in memory writes a register |
| mem_is_load | input | 1 | Instruction in memory is a load |
| mem_alu_result | input | DW | ALU result held in the execute/memory register |
| stall | output | 1 | Hold PC and fetch/decode, bubble into decode/execute |
| fwd_sel_a | output | 1 | Operand A comes from mem_alu_result (1) or register file (0) |
| fwd_sel_b | output | 1 | Operand B comes from mem_alu_result (1) or register file (0) |
| br_taken | output | 1 | Decode branch resolves taken this cycle |
| fetch_flush | output | 1 | Discard the instruction fetched behind the branch |

## Verification
The block holds no state. A wrong decision in a per-operand tracker or in the comparator shows up at the ports in the same cycle as the stimulus that exposes it: a missing or extra `stall`, a wrong forward select, or a taken result computed from a stale operand. The bench checks every port on every cycle against an independent model. It also replays short pipeline sequences in which it advances a model of the execute and memory slots under the block's own stall. This way a stall held for the wrong number of cycles shows up as a wrong stall count before the branch resolves.

// File: rtl/bhz_pkg.sv
// Shared types for the decode-stage branch hazard unit.
// Assumes a two-bit opcode from the decoder; the encodings are fixed.
package bhz_pkg;
    typedef enum logic [1:0] {
        BR_NONE    = 2'b00,
        BR_EQ      = 2'b01,
        BR_ZERO    = 2'b10,
        BR_NONZERO = 2'b11
    } br_op_e;

    localparam int NSRC = 2;
endpackage

// File: rtl/bhz_operand_track.sv
// Per-operand hazard tracker: decides whether one decode branch source
// must wait for an in-flight producer, or can take the EX/MEM ALU result.
// Assumes the writeback producer is covered by write-then-read in the
// register file and so needs no input here.
module bhz_operand_track #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic          used,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_wr_en,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr_en,
    input  logic          mem_is_load,
    output logic          stall_req,
    output logic          fwd_hit
);
    logic live;
    logic ex_match;
    logic mem_match;

    // Match each in-flight producer against a live, nonzero source.
    always_comb begin
        live      = used && (src != '0);
        ex_match  = live && ex_wr_en  && (ex_dst  == src);
        mem_match = live && mem_wr_en && (mem_dst == src);
    end

    // EX producer of any kind waits; a MEM load waits; a MEM ALU op forwards.
    always_comb begin
        stall_req = ex_match || (mem_match && mem_is_load);
        fwd_hit   = mem_match && !mem_is_load;
    end
endmodule

// File: rtl/bhz_compare.sv
// Decode-stage branch comparator with its operand muxes.
// Assumes operand selects come from the trackers; the result is held low
// while the branch is stalled, since its operands may be stale.
module bhz_compare
    import bhz_pkg::*;
#(
    parameter int DW = 32
) (
    input  br_op_e        op,
    input  logic          hold,
    input  logic [DW-1:0] rf_a,
    input  logic [DW-1:0] rf_b,
    input  logic [DW-1:0] fwd_val,
    input  logic [NSRC-1:0] fwd_sel,
    output logic          taken
);
    logic [DW-1:0] rf_val [NSRC];
    logic [DW-1:0] opnd   [NSRC];

    assign rf_val[0] = rf_a;
    assign rf_val[1] = rf_b;

    // One operand mux per comparator input.
    for (genvar i = 0; i < NSRC; i++) begin : g_mux
        assign opnd[i] = fwd_sel[i] ? fwd_val : rf_val[i];
    end

    // Resolve the branch from the selected operands.
    always_comb begin
        taken = 1'b0;
        if (!hold) begin
            case (op)
                BR_EQ:      taken = (opnd[0] == opnd[1]);
                BR_ZERO:    taken = (opnd[0] == '0);
                BR_NONZERO: taken = (opnd[0] != '0);
                default:    taken = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/decode_branch_hazard.sv
// Top of the decode-stage branch hazard unit: two operand trackers and
// the comparator. Purely combinational; the surrounding pipeline applies
// stall (hold PC and IF/ID, bubble ID/EX) and fetch_flush (no delay slot).
module decode_branch_hazard
    import bhz_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic [1:0]    id_br_op,
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    input  logic [DW-1:0] rf_data_a,
    input  logic [DW-1:0] rf_data_b,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_wr_en,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr_en,
    input  logic          mem_is_load,
    input  logic [DW-1:0] mem_alu_result,
    output logic          stall,
    output logic          fwd_sel_a,
    output logic          fwd_sel_b,
    output logic          br_taken,
    output logic          fetch_flush
);
    br_op_e          op;
    logic [NSRC-1:0] src_used;
    logic [AW-1:0]   src_reg [NSRC];
    logic [NSRC-1:0] stall_req;
    logic [NSRC-1:0] fwd_hit;

    // Decode which sources the branch reads: B only for the equality form.
    always_comb begin
        op          = br_op_e'(id_br_op);
        src_used[0] = (op != BR_NONE);
        src_used[1] = (op == BR_EQ);
        src_reg[0]  = id_src_a;
        src_reg[1]  = id_src_b;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_trk
        bhz_operand_track #(.AW(AW)) u_trk (
            .src         (src_reg[i]),
            .used        (src_used[i]),
            .ex_dst      (ex_dst),
            .ex_wr_en    (ex_wr_en),
            .mem_dst     (mem_dst),
            .mem_wr_en   (mem_wr_en),
            .mem_is_load (mem_is_load),
            .stall_req   (stall_req[i]),
            .fwd_hit     (fwd_hit[i])
        );
    end

    assign stall     = |stall_req;
    assign fwd_sel_a = fwd_hit[0];
    assign fwd_sel_b = fwd_hit[1];

    bhz_compare #(.DW(DW)) u_cmp (
        .op      (op),
        .hold    (stall),
        .rf_a    (rf_data_a),
        .rf_b    (rf_data_b),
        .fwd_val (mem_alu_result),
        .fwd_sel (fwd_hit),
        .taken   (br_taken)
    );

    assign fetch_flush = br_taken;
endmodule

// File: rtl/bhz_checker.sv
// Assertion checker for decode_branch_hazard, attached by bind below.
// All relations are between ports in the same cycle, since the unit is
// combinational.
module bhz_checker #(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input logic [1:0]    id_br_op,
    input logic [AW-1:0] id_src_a,
    input logic [AW-1:0] id_src_b,
    input logic [DW-1:0] rf_data_a,
    input logic [DW-1:0] rf_data_b,
    input logic [AW-1:0] ex_dst,
    input logic          ex_wr_en,
    input logic [AW-1:0] mem_dst,
    input logic          mem_wr_en,
    input logic          mem_is_load,
    input logic [DW-1:0] mem_alu_result,
    input logic          stall,
    input logic          fwd_sel_a,
    input logic          fwd_sel_b,
    input logic          br_taken,
    input logic          fetch_flush
);
    logic [DW-1:0] va;
    logic [DW-1:0] vb;

    // Operand values as seen through the reported forward selects.
    always_comb begin
        va = fwd_sel_a ? mem_alu_result : rf_data_a;
        vb = fwd_sel_b ? mem_alu_result : rf_data_b;
    end

    // Check port relations each time any port changes.
    always_comb begin
        p_eq_result_r1: assert (!(id_br_op == 2'b01 && !stall) || (br_taken == (va == vb)))
            else $error("equality branch resolved wrongly");
        p_zero_result_r2: assert (!(id_br_op == 2'b10 && !stall) || (br_taken == (va == '0)))
            else $error("zero test resolved wrongly");
        p_nonzero_result_r2: assert (!(id_br_op == 2'b11 && !stall) || (br_taken == (va != '0)))
            else $error("nonzero test resolved wrongly");
        p_b_unused_r2: assert (!id_br_op[1] || !fwd_sel_b)
            else $error("operand B forwarded for a single-source test");
        p_idle_quiet_r3: assert (id_br_op != 2'b00 ||
                                 !(stall || fwd_sel_a || fwd_sel_b || br_taken || fetch_flush))
            else $error("non-branch produced activity");
        p_ex_stall_r4: assert (!(id_br_op != 2'b00 && ex_wr_en && ex_dst != '0 &&
                                 ex_dst == id_src_a) || stall)
            else $error("EX producer of A did not stall");
        p_load_stall_r5: assert (!(id_br_op != 2'b00 && mem_wr_en && mem_is_load &&
                                   mem_dst != '0 && mem_dst == id_src_a) || stall)
            else $error("MEM load producer of A did not stall");
        p_fwd_a_r6: assert (!(id_br_op != 2'b00 && mem_wr_en && !mem_is_load &&
                              mem_dst != '0 && mem_dst == id_src_a) || fwd_sel_a)
            else $error("MEM ALU producer of A not forwarded");
        p_zero_reg_r7: assert (!(id_src_a == '0) || !fwd_sel_a)
            else $error("register 0 forwarded");
        p_hold_quiet_r8: assert (!stall || !(br_taken || fetch_flush))
            else $error("branch resolved while stalled");
        p_flush_r8: assert (stall || (fetch_flush == br_taken))
            else $error("flush disagrees with taken");
    end
endmodule

bind decode_branch_hazard bhz_checker #(.AW(AW), .DW(DW)) u_bhz_chk (
    .id_br_op       (id_br_op),
    .id_src_a       (id_src_a),
    .id_src_b       (id_src_b),
    .rf_data_a      (rf_data_a),
    .rf_data_b      (rf_data_b),
    .ex_dst         (ex_dst),
    .ex_wr_en       (ex_wr_en),
    .mem_dst        (mem_dst),
    .mem_wr_en      (mem_wr_en),
    .mem_is_load    (mem_is_load),
    .mem_alu_result (mem_alu_result),
    .stall          (stall),
    .fwd_sel_a      (fwd_sel_a),
    .fwd_sel_b      (fwd_sel_b),
    .br_taken       (br_taken),
    .fetch_flush    (fetch_flush)
);

// File: tb/decode_branch_hazard_bench.sv
`timescale 1ns/1ps
// Bench for decode_branch_hazard: behavioural reference compared every
// clock, plus directed cases and pipeline-advance sequences.
module decode_branch_hazard_bench;
    localparam int AW = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [1:0]    id_br_op = '0;
    logic [AW-1:0] id_src_a = '0, id_src_b = '0, ex_dst = '0, mem_dst = '0;
    logic [DW-1:0] rf_data_a = '0, rf_data_b = '0, mem_alu_result = '0;
    logic          ex_wr_en = 1'b0, mem_wr_en = 1'b0, mem_is_load = 1'b0;
    logic          stall, fwd_sel_a, fwd_sel_b, br_taken, fetch_flush;

    int checks = 0;
    int failures = 0;

    decode_branch_hazard #(.AW(AW), .DW(DW)) u_decode_branch_hazard (
        .id_br_op(id_br_op), .id_src_a(id_src_a), .id_src_b(id_src_b),
        .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
        .ex_dst(ex_dst), .ex_wr_en(ex_wr_en),
        .mem_dst(mem_dst), .mem_wr_en(mem_wr_en), .mem_is_load(mem_is_load),
        .mem_alu_result(mem_alu_result),
        .stall(stall), .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
        .br_taken(br_taken), .fetch_flush(fetch_flush)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    logic e_stall, e_fa, e_fb, e_taken;
    string e_tag;
    task automatic model();
        bit ua, ub, ld_hit, ex_hit;
        logic [DW-1:0] va, vb;
        ua = (id_br_op != 2'b00);
        ub = (id_br_op == 2'b01);
        ex_hit = ex_wr_en && ex_dst != 0 &&
                 ((ua && ex_dst == id_src_a) || (ub && ex_dst == id_src_b));
        ld_hit = mem_wr_en && mem_is_load && mem_dst != 0 &&
                 ((ua && mem_dst == id_src_a) || (ub && mem_dst == id_src_b));
        e_stall = ex_hit || ld_hit;
        e_fa = ua && id_src_a != 0 && mem_wr_en && !mem_is_load && mem_dst == id_src_a;
        e_fb = ub && id_src_b != 0 && mem_wr_en && !mem_is_load && mem_dst == id_src_b;
        va = e_fa ? mem_alu_result : rf_data_a;
        vb = e_fb ? mem_alu_result : rf_data_b;
        e_taken = 1'b0;
        if (!e_stall) begin
            if (id_br_op == 2'b01) e_taken = (va == vb);
            if (id_br_op == 2'b10) e_taken = (va == 0);
            if (id_br_op == 2'b11) e_taken = (va != 0);
        end
        if (!ua)          e_tag = "R3";
        else if (ex_hit)  e_tag = "R4";
        else if (ld_hit)  e_tag = "R5";
        else if (e_fa || e_fb) e_tag = "R6";
        else if (ub)      e_tag = "R1";
        else              e_tag = "R2";
    endtask

    // Sample at the falling edge, compare all outputs, then wait for the next rise.
    task automatic step(string tag);
        @(negedge clk);
        model();
        if (tag == "") tag = e_tag;
        chk(tag, "stall", stall, e_stall);
        chk(tag, "fwd_sel_a", fwd_sel_a, e_fa);
        chk(tag, "fwd_sel_b", fwd_sel_b, e_fb);
        chk(tag, "br_taken", br_taken, e_taken);
        chk("R8", "fetch_flush", fetch_flush, e_taken);
        @(posedge clk); #1;
    endtask

    task automatic clear_pipe();
        ex_dst = '0; ex_wr_en = 0; mem_dst = '0; mem_wr_en = 0; mem_is_load = 0;
        mem_alu_result = '0;
    endtask

    // Producer directly ahead of a nonzero test on r3; pipeline advanced under stall.
    task automatic run_seq(bit is_load, int exp_stalls);
        int n_stall = 0;
        bit mem_load_now;
        clear_pipe();
        id_br_op = 2'b11; id_src_a = 5'd3; rf_data_a = '0;
        ex_dst = 5'd3; ex_wr_en = 1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!stall) break;
            n_stall++;
            chk("R8", "taken during stall", br_taken, 0);
            @(posedge clk); #1;
            mem_load_now = mem_wr_en && mem_is_load;
            // Memory slot retires to writeback: write-then-read makes value visible.
            if (mem_load_now) rf_data_a = 32'd7;
            mem_dst = ex_dst; mem_wr_en = ex_wr_en; mem_is_load = ex_wr_en && is_load;
            mem_alu_result = (ex_wr_en && !is_load) ? 32'd7 : 32'hdead;
            if (!ex_wr_en) begin mem_wr_en = 0; mem_is_load = 0; end
            ex_dst = '0; ex_wr_en = 0;
        end
        chk("R10", "stall cycles", n_stall, exp_stalls);
        chk("R10", "fwd_sel_a after stall", fwd_sel_a, is_load ? 0 : 1);
        chk("R10", "resolved taken", br_taken, 1);
        if (is_load) chk("R9", "regfile path after load", fwd_sel_a, 0);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        // R3: all-zero inputs, then a non-branch with matching producers.
        step("R3");
        id_br_op = 2'b00; id_src_a = 5'd1; ex_dst = 5'd1; ex_wr_en = 1;
        mem_dst = 5'd1; mem_wr_en = 1; mem_is_load = 1;
        step("R3");
        clear_pipe();
        // R1: equality, equal then unequal.
        id_br_op = 2'b01; id_src_a = 5'd4; id_src_b = 5'd5;
        rf_data_a = 32'd9; rf_data_b = 32'd9; step("R1");
        rf_data_b = 32'd8; step("R1");
        // R2: zero / nonzero tests; B ignored.
        id_br_op = 2'b10; rf_data_a = 0; rf_data_b = 32'd1; step("R2");
        id_br_op = 2'b11; step("R2");
        rf_data_a = 32'd2; step("R2");
        id_br_op = 2'b10; ex_dst = 5'd5; ex_wr_en = 1; step("R2");
        clear_pipe(); mem_dst = 5'd5; mem_wr_en = 1; mem_alu_result = 0; step("R2");
        chk("R2", "fwd_sel_b single-source", fwd_sel_b, 0);
        clear_pipe();
        // R4: ALU and load in EX on B of equality.
        id_br_op = 2'b01; ex_dst = 5'd5; ex_wr_en = 1; step("R4");
        clear_pipe();
        // R5: load vs non-load in MEM.
        mem_dst = 5'd4; mem_wr_en = 1; mem_is_load = 1; step("R5");
        mem_is_load = 0; mem_alu_result = 32'd1; step("R5");
        // R6: forward B from MEM, equal to A.
        clear_pipe(); rf_data_a = 32'd33; rf_data_b = 32'd0;
        mem_dst = 5'd5; mem_wr_en = 1; mem_alu_result = 32'd33; step("R6");
        chk("R6", "forwarded compare taken", br_taken, 1);
        // R7: register 0.
        clear_pipe(); id_src_a = 0; id_src_b = 0;
        ex_dst = 0; ex_wr_en = 1; mem_dst = 0; mem_wr_en = 1; mem_is_load = 1; step("R7");
        mem_is_load = 0; mem_alu_result = 32'd5; step("R7");
        // R9: no MEM match uses regfile data.
        clear_pipe(); id_src_a = 5'd6; id_src_b = 5'd7; rf_data_a = 1; rf_data_b = 1;
        mem_dst = 5'd8; mem_wr_en = 1; mem_alu_result = 32'd2; step("R9");
        // R10: pipeline sequences.
        run_seq(0, 1);
        run_seq(1, 2);
        // Random traffic, compared every cycle.
        for (int i = 0; i < 400; i++) begin
            id_br_op = 2'($urandom_range(0, 3));
            id_src_a = AW'($urandom_range(0, 3)); id_src_b = AW'($urandom_range(0, 3));
            ex_dst = AW'($urandom_range(0, 3)); mem_dst = AW'($urandom_range(0, 3));
            ex_wr_en = 1'($urandom_range(0, 1)); mem_wr_en = 1'($urandom_range(0, 1));
            mem_is_load = 1'($urandom_range(0, 1));
            rf_data_a = DW'($urandom_range(0, 2)); rf_data_b = DW'($urandom_range(0, 2));
            mem_alu_result = DW'($urandom_range(0, 2));
            step("");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule